// File: doc/BRIEF.md
# Jumper-Selectable Periodic Interrupt Generator

This block produces a repeating interrupt pulse for a small 8-bit processor board. After a quiet interval it raises the interrupt request for a fixed number of clock cycles, then drops it and starts the next quiet interval. Two configuration jumper bits choose the length of the quiet interval from four fixed values. Every cycle of both phases is counted on the full-rate clock. A one-cycle clear input lets the processor side cancel the current phase and restart a full quiet interval.

Two handshake lines go to parallel-interface peripherals and move in step with the pulse. The strobe line is low exactly while the interrupt is raised. The diagnostic line takes the level of a push-button at the start of each pulse, keeps that level until the pulse ends, and is high between pulses. A status output mirrors the pulse so that phase lengths can be measured directly.

Top module: `irq_pacer`

## Requirements
- R1: The quiet interval (interrupt low) is 0x300 cycles when `jumper_sel` is 2'b00, 0x380 for 2'b01, 0x700 for 2'b10 and 0x780 for 2'b11. The first interval is counted from the first cycle after reset is released.
- R2: Unless a clear arrives, the interrupt request stays high for exactly 32 consecutive cycles.
- R3: `jumper_sel` is read only when a new interval is loaded: at reset, at the end of a pulse and on a clear. A change in the middle of an interval does not alter that interval, but it does set the length of the next one.
- R4: `hs_strobe_n` is low exactly in the cycles where `irq_req` is high, and `pulse_busy` equals `irq_req` in every cycle.
- R5: `hs_diag` takes the level of `diag_btn` from the clock edge that starts the pulse. It holds that level for the whole pulse even if the button changes, and it is high whenever the interrupt is low.
- R6: A one-cycle `restart_clr` during the quiet interval restarts it. The next pulse rises a full selected interval after the edge that sampled the clear.
- R7: While reset is held and after it is released, the interrupt is low, `hs_strobe_n` is high, `hs_diag` is high and `pulse_busy` is low.
- R8: A `restart_clr` sampled during a pulse drops the interrupt from the next cycle, sets `hs_diag` high, and is followed by a full selected quiet interval.
- R9: A `restart_clr` sampled in the last cycle of a quiet interval wins over the pulse start. No pulse is raised, and a full selected interval follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock that both phases are counted on |
| rst | input | 1 | Synchronous reset, active high |
| jumper_sel | input | 2 | Jumper bits that choose the quiet interval length |
| diag_btn | input | 1 | Diagnostic push-button level |
| restart_clr | input | 1 | Clear that restarts a full quiet interval |
| irq_req | output | 1 | Interrupt request, active high |
| hs_strobe_n | output | 1 | Handshake line, low during the pulse |
| hs_diag | output | 1 | Handshake line that carries the button level captured for the pulse |
| pulse_busy | output | 1 | Status, high while the pulse is active |

## Verification
The external clear can fall in the same cycle as either terminal count of the phase counter. When it coincides with the end of a quiet interval it competes with the pulse start. When it arrives inside a pulse it competes with the normal pulse end. The bench drives the clear on the computed final sample of a quiet interval, and also a few cycles into a pulse. It then requires the interrupt to be low on the very next sample, with no pulse rising, and a full selected interval to be measured afterwards.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    // Phase of the pacer: quiet interval or active pulse
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_PULSE = 1'b1
    } phase_e;

    // Phase transition events, valid in the cycle before the edge that applies them
    typedef struct packed {
        logic enter;   // quiet interval ends, pulse begins
        logic leave;   // pulse ends, normally or through a clear
    } edge_ev_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned max_of5(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d,
                                            input int unsigned e);
        return max2(max2(max2(a, b), max2(c, d)), e);
    endfunction

    // Bits needed to hold the value v
    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/irqp_gap_select.sv
module irqp_gap_select #(
    parameter int unsigned GAP_SEL0 = 768,
    parameter int unsigned GAP_SEL1 = 896,
    parameter int unsigned GAP_SEL2 = 1792,
    parameter int unsigned GAP_SEL3 = 1920,
    parameter int unsigned CNT_W    = 11
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] load_val
);
    localparam int unsigned N_CHOICE = 4;

    logic [CNT_W-1:0] choice [N_CHOICE];

    for (genvar i = 0; i < N_CHOICE; i++) begin : g_choice
        localparam int unsigned GVAL = (i == 0) ? GAP_SEL0 :
                                       (i == 1) ? GAP_SEL1 :
                                       (i == 2) ? GAP_SEL2 : GAP_SEL3;
        assign choice[i] = CNT_W'(GVAL);
    end

    assign load_val = choice[sel];

endmodule

// File: rtl/irqp_timer.sv
module irqp_timer
    import irqp_pkg::*;
#(
    parameter int unsigned CNT_W     = 11,
    parameter int unsigned PULSE_CYC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] load_val,
    output phase_e           phase_q,
    output edge_ev_t         ev
);
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // Counter reads 1 in the final cycle of either phase
    assign last = (cnt_q <= CNT_W'(1));

    always_comb begin
        ev.enter = !clr && (phase_q == PH_IDLE) && last;
        ev.leave = (phase_q == PH_PULSE) && (clr || last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= load_val;
        end else if (clr) begin
            // the clear wins over either terminal count
            phase_q <= PH_IDLE;
            cnt_q   <= load_val;
        end else if (last) begin
            if (phase_q == PH_IDLE) begin
                phase_q <= PH_PULSE;
                cnt_q   <= CNT_W'(PULSE_CYC);
            end else begin
                phase_q <= PH_IDLE;
                cnt_q   <= load_val;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/irqp_handshake.sv
module irqp_handshake
    import irqp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phase_e   phase_q,
    input  edge_ev_t ev,
    input  logic     btn,
    output logic     irq,
    output logic     strobe_n,
    output logic     diag,
    output logic     busy
);
    logic diag_q;

    assign irq      = (phase_q == PH_PULSE);
    assign busy     = (phase_q == PH_PULSE);
    assign strobe_n = (phase_q != PH_PULSE);
    assign diag     = diag_q;

    // Capture the button on the edge that starts the pulse and force high on the edge that ends it
    always_ff @(posedge clk) begin
        if (rst) begin
            diag_q <= 1'b1;
        end else if (ev.enter) begin
            diag_q <= btn;
        end else if (ev.leave) begin
            diag_q <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_pacer.sv
module irq_pacer
    import irqp_pkg::*;
#(
    parameter int unsigned GAP_SEL0  = 768,
    parameter int unsigned GAP_SEL1  = 896,
    parameter int unsigned GAP_SEL2  = 1792,
    parameter int unsigned GAP_SEL3  = 1920,
    parameter int unsigned PULSE_CYC = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] jumper_sel,
    input  logic       diag_btn,
    input  logic       restart_clr,
    output logic       irq_req,
    output logic       hs_strobe_n,
    output logic       hs_diag,
    output logic       pulse_busy
);
    localparam int unsigned CNT_MAX = max_of5(GAP_SEL0, GAP_SEL1, GAP_SEL2, GAP_SEL3, PULSE_CYC);
    localparam int unsigned CNT_W   = bits_for(CNT_MAX);

    logic [CNT_W-1:0] load_val;
    phase_e           phase_q;
    edge_ev_t         ev;

    irqp_gap_select #(
        .GAP_SEL0 (GAP_SEL0),
        .GAP_SEL1 (GAP_SEL1),
        .GAP_SEL2 (GAP_SEL2),
        .GAP_SEL3 (GAP_SEL3),
        .CNT_W    (CNT_W)
    ) u_sel (
        .sel      (jumper_sel),
        .load_val (load_val)
    );

    irqp_timer #(
        .CNT_W     (CNT_W),
        .PULSE_CYC (PULSE_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart_clr),
        .load_val (load_val),
        .phase_q  (phase_q),
        .ev       (ev)
    );

    irqp_handshake u_hs (
        .clk      (clk),
        .rst      (rst),
        .phase_q  (phase_q),
        .ev       (ev),
        .btn      (diag_btn),
        .irq      (irq_req),
        .strobe_n (hs_strobe_n),
        .diag     (hs_diag),
        .busy     (pulse_busy)
    );

endmodule

// File: rtl/irqp_chk.sv
module irqp_chk
    import irqp_pkg::*;
#(
    parameter int unsigned GAP_SEL0  = 768,
    parameter int unsigned GAP_SEL1  = 896,
    parameter int unsigned GAP_SEL2  = 1792,
    parameter int unsigned GAP_SEL3  = 1920,
    parameter int unsigned PULSE_CYC = 32
) (
    input logic clk,
    input logic rst,
    input logic restart_clr,
    input logic irq_req,
    input logic hs_strobe_n,
    input logic hs_diag
);
    localparam int unsigned GAP_W = bits_for(max_of5(GAP_SEL0, GAP_SEL1, GAP_SEL2, GAP_SEL3, 1)) + 1;
    localparam int unsigned RUN_W = bits_for(PULSE_CYC) + 1;

    logic [GAP_W-1:0] gap_q;
    logic [RUN_W-1:0] run_q;

    // Length of the current quiet interval, in edges since the last reload
    always_ff @(posedge clk) begin
        if (rst || restart_clr || irq_req) gap_q <= '0;
        else                               gap_q <= gap_q + 1'b1;
    end

    // Length of the current pulse
    always_ff @(posedge clk) begin
        if (rst || !irq_req) run_q <= '0;
        else                 run_q <= run_q + 1'b1;
    end

    // R1
    gap_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> (gap_q == GAP_W'(GAP_SEL0) || gap_q == GAP_W'(GAP_SEL1) ||
                            gap_q == GAP_W'(GAP_SEL2) || gap_q == GAP_W'(GAP_SEL3)));

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(irq_req) && !$past(restart_clr)) |-> (run_q == RUN_W'(PULSE_CYC)));

    // R2
    pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(PULSE_CYC));

    // R4
    strobe_chk: assert property (@(posedge clk) disable iff (rst)
        hs_strobe_n == !irq_req);

    // R5
    diag_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> hs_diag);

    // R5
    diag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && $past(irq_req)) |-> $stable(hs_diag));

    // R6
    clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        restart_clr |=> !irq_req);

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq_req && hs_strobe_n && hs_diag));

endmodule

bind irq_pacer irqp_chk #(
    .GAP_SEL0  (GAP_SEL0),
    .GAP_SEL1  (GAP_SEL1),
    .GAP_SEL2  (GAP_SEL2),
    .GAP_SEL3  (GAP_SEL3),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .restart_clr (restart_clr),
    .irq_req     (irq_req),
    .hs_strobe_n (hs_strobe_n),
    .hs_diag     (hs_diag)
);

// File: tb/tb_irq_pacer.sv
module tb_irq_pacer;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 32;
    localparam int CAP        = 5000;

    int gaps [4] = '{768, 896, 1792, 1920};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] jumper_sel = 2'b00;
    logic       diag_btn = 1'b1;
    logic       restart_clr = 1'b0;
    logic       irq_req, hs_strobe_n, hs_diag, pulse_busy;

    int checks = 0;
    int fails  = 0;

    irq_pacer dut (
        .clk         (clk),
        .rst         (rst),
        .jumper_sel  (jumper_sel),
        .diag_btn    (diag_btn),
        .restart_clr (restart_clr),
        .irq_req     (irq_req),
        .hs_strobe_n (hs_strobe_n),
        .hs_diag     (hs_diag),
        .pulse_busy  (pulse_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        jumper_sel  = s;
        rst         = 1'b1;
        restart_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Count consecutive samples with irq at lvl; count handshake mismatches against exp_diag
    task automatic run_len(input logic lvl, input logic exp_diag, output int n, output int bad);
        n = 0;
        bad = 0;
        while (irq_req === lvl && n < CAP) begin
            if (hs_strobe_n !== ~irq_req || pulse_busy !== irq_req || hs_diag !== exp_diag) bad++;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic one_clear();
        restart_clr = 1'b1;
        @(negedge clk);
        restart_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int n, bad;
        logic cap;

        // R7: reset state
        do_reset(2'b00);
        check(irq_req === 1'b0,     "R7 irq after reset",    irq_req,     0);
        check(hs_strobe_n === 1'b1, "R7 strobe after reset", hs_strobe_n, 1);
        check(hs_diag === 1'b1,     "R7 diag after reset",   hs_diag,     1);
        check(pulse_busy === 1'b0,  "R7 busy after reset",   pulse_busy,  0);

        // R1 R2 R4 R5: sweep every jumper setting
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            cap = s[0];
            diag_btn = cap;
            run_len(1'b0, 1'b1, n, bad);
            check(n == gaps[s], "R1 first gap", n, gaps[s]);
            check(bad == 0,     "R4 handshake in gap", bad, 0);
            diag_btn = ~cap;    // moving the button mid-pulse must not matter
            run_len(1'b1, cap, n, bad);
            check(n == PULSE,   "R2 pulse length", n, PULSE);
            check(bad == 0,     "R5 diag held, R4 strobe in pulse", bad, 0);
            check(hs_diag === 1'b1, "R5 diag high after pulse", hs_diag, 1);
            cap = diag_btn;
            run_len(1'b0, 1'b1, n, bad);
            check(n == gaps[s], "R1 second gap", n, gaps[s]);
            run_len(1'b1, cap, n, bad);
            check(n == PULSE && bad == 0, "R5 second pulse capture", bad, 0);
        end

        // R3: jumper change mid-interval applies only to the next interval
        do_reset(2'b00);
        repeat (50) @(negedge clk);
        jumper_sel = 2'b11;
        run_len(1'b0, 1'b1, n, bad);
        check(n == gaps[0] - 50, "R3 current gap unchanged", n, gaps[0] - 50);
        run_len(1'b1, diag_btn, n, bad);
        run_len(1'b0, 1'b1, n, bad);
        check(n == gaps[3], "R3 next gap uses new jumpers", n, gaps[3]);

        // R6: clear during the quiet interval
        do_reset(2'b01);
        repeat (100) @(negedge clk);
        one_clear();
        run_len(1'b0, 1'b1, n, bad);
        check(n == gaps[1], "R6 gap restarted by clear", n, gaps[1]);

        // R8: clear in the middle of a pulse
        repeat (5) @(negedge clk);
        one_clear();
        check(irq_req === 1'b0, "R8 pulse ended by clear", irq_req, 0);
        check(hs_diag === 1'b1, "R8 diag high after clear", hs_diag, 1);
        run_len(1'b0, 1'b1, n, bad);
        check(n == gaps[1], "R8 full gap after clear", n, gaps[1]);

        // R9: clear on the last quiet cycle suppresses the pulse
        do_reset(2'b10);
        repeat (gaps[2] - 1) @(negedge clk);
        check(irq_req === 1'b0, "R9 still quiet before clear", irq_req, 0);
        one_clear();
        check(irq_req === 1'b0, "R9 no pulse on clear", irq_req, 0);
        run_len(1'b0, 1'b1, n, bad);
        check(n == gaps[2], "R9 full gap after clear", n, gaps[2]);

        summary();
    end

endmodule